// File: doc/BRIEF.md
# Serial Channel Command and Mode-Register Front End

This block is the host-side register front end of one asynchronous serial channel. A host reaches two mode registers through one shared access port. A pointer inside the block selects which of the two registers an access reaches. The first access after reset, or after a pointer-reset command, goes to the first mode register and then moves the pointer to the second. Later accesses stay on the second register.

A separate command write carries a 4-bit code in the upper nibble of the data word. Each code that is accepted can raise a pulse one cycle wide toward the receiver, the transmitter, the status logic, the interrupt logic or the mode pointer. The block also holds the level of the active-low request-to-send output. The block enforces a minimum spacing between command writes. A write that comes too soon after the last accepted one is dropped, and a sticky violation flag is set.

Top module: `sio_cmd_front`

## Requirements
- R1: After reset, `mr_sel` is 0, `mode_rdata` shows the first mode register's reset value (8'h00 by default), `rts_n` is 1, `gap_err` is 0 and every command pulse is low.
- R2: A mode access is a write (`mode_wr`) or a read (`mode_rd`). A mode access made while `mr_sel` is 0 reaches the first mode register, and `mr_sel` becomes 1 after the clock edge.
- R3: A mode access made while `mr_sel` is 1 reaches the second mode register, and `mr_sel` stays 1. `mode_rdata` always shows the register that `mr_sel` selects.
- R4: An accepted command with code 4'b0001 in `wdata[7:4]` raises `ptr_reset_p` and returns `mr_sel` to 0. This holds even when a mode access happens in the same cycle. That access still reaches the register that was selected before the edge.
- R5: An accepted command with code 4'b0010 raises `rx_reset_p`. Code 4'b0011 raises `tx_reset_p`. Each pulse is high only during the write cycle.
- R6: An accepted command with code 4'b0100 raises `err_clr_p`, which clears status bits [7:4]. Code 4'b0101 raises `brk_clr_p`, which clears the break-change interrupt flag. Each pulse is high only during the write cycle.
- R7: Accepted code 4'b1000 drives `rts_n` to 0, and accepted code 4'b1001 drives it to 1. The level holds until the next such command or a reset.
- R8: Codes 4'b0000, 4'b1011 and 4'b1101, and every other code not named in R4 to R7, raise no pulse and leave `rts_n` and `mr_sel` unchanged.
- R9: A command write is accepted only if it comes at least MIN_GAP (3) cycles after the last accepted command write. A write in cycle c+3 after an accepted write in cycle c is accepted. A write in cycle c+1 or c+2 is dropped: it raises no pulse, changes no state and does not restart the spacing window.
- R10: A dropped command write sets `gap_err`. `gap_err` stays at 1 until reset.
- R11: `wdata[3:0]` has no effect on a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write to the mode register that the pointer selects |
| mode_rd | input | 1 | Read access to the selected mode register (advances the pointer) |
| cmd_wr | input | 1 | Command write strobe |
| wdata | input | 8 | Write data; bits [7:4] hold the command code |
| mode_rdata | output | 8 | Contents of the mode register that the pointer selects |
| mr_sel | output | 1 | Mode pointer: 0 selects the first register, 1 the second |
| rx_reset_p | output | 1 | Receiver reset pulse |
| tx_reset_p | output | 1 | Transmitter reset pulse |
| err_clr_p | output | 1 | Error-status clear pulse |
| brk_clr_p | output | 1 | Break-change interrupt clear pulse |
| ptr_reset_p | output | 1 | Mode pointer reset pulse |
| rts_n | output | 1 | Request-to-send, active low |
| gap_err | output | 1 | Sticky command-spacing violation flag |

## Verification
The properties assume that the host holds each strobe for exactly one cycle at a time. They also assume that `wdata` is valid whenever `cmd_wr` or `mode_wr` is high. The rule that no R8 code disturbs `rts_n` or `mr_sel` is checked only in cycles with no mode access, because a concurrent access legitimately moves the pointer. The stimulus drives every strobe as a one-cycle pulse set up on the falling edge. It spaces the table-driven command writes exactly three cycles apart, so they sit on the boundary that R9 allows. Early writes appear only in the directed spacing test.

// File: rtl/sio_cmd_pkg.sv
package sio_cmd_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      CMD_NOP      = 4'h0,
      CMD_PTR_RST  = 4'h1,
      CMD_RX_RST   = 4'h2,
      CMD_TX_RST   = 4'h3,
      CMD_ERR_CLR  = 4'h4,
      CMD_BRK_CLR  = 4'h5,
      CMD_RTS_ON   = 4'h8,
      CMD_RTS_OFF  = 4'h9
   } cmd_code_e;

   typedef struct packed {
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic brk_clr;
      logic ptr_rst;
      logic rts_on;
      logic rts_off;
   } cmd_dec_t;

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_cmd_pkg::*;
(
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   output cmd_dec_t          dec
);

   always_comb begin
      dec = '0;
      if (valid) begin
         case (cmd_code_e'(code))
            CMD_PTR_RST: dec.ptr_rst = 1'b1;
            CMD_RX_RST:  dec.rx_rst  = 1'b1;
            CMD_TX_RST:  dec.tx_rst  = 1'b1;
            CMD_ERR_CLR: dec.err_clr = 1'b1;
            CMD_BRK_CLR: dec.brk_clr = 1'b1;
            CMD_RTS_ON:  dec.rts_on  = 1'b1;
            CMD_RTS_OFF: dec.rts_off = 1'b1;
            default:     dec = '0;
         endcase
      end
   end

endmodule

// File: rtl/sio_cmd_gap.sv
module sio_cmd_gap #(
   parameter int MIN_GAP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ok,
   output logic viol
);

   if (MIN_GAP < 1) begin : g_bad
      $error("sio_cmd_gap: MIN_GAP must be at least 1");
   end

   if (MIN_GAP <= 1) begin : g_free
      assign ok   = 1'b1;
      assign viol = 1'b0;
   end else begin : g_guard
      localparam int CNT_W = $clog2(MIN_GAP);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_GAP - 1);

      logic [CNT_W-1:0] cnt_q;
      logic             viol_q;

      assign ok   = (cnt_q == LIMIT);
      assign viol = viol_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= LIMIT;
         end else if (req && ok) begin
            cnt_q <= '0;
         end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            viol_q <= 1'b0;
         end else if (req && !ok) begin
            viol_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/sio_mr_ptr.sv
module sio_mr_ptr #(
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] MR1_RST = '0,
   parameter logic [DATA_W-1:0] MR2_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ptr_clr,
   output logic [DATA_W-1:0] rdata,
   output logic              sel
);

   localparam int NREG = 2;

   logic [NREG-1:0][DATA_W-1:0] mr_q;
   logic                        sel_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_V = (i == 0) ? MR1_RST : MR2_RST;
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_V;
         end else if (wr && (sel_q == 1'(i))) begin
            q <= wdata;
         end
      end

      assign mr_q[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
      end else if (ptr_clr) begin
         sel_q <= 1'b0;
      end else if (wr || rd) begin
         sel_q <= 1'b1;
      end
   end

   assign sel   = sel_q;
   assign rdata = mr_q[sel_q];

endmodule

// File: rtl/sio_cmd_front.sv
module sio_cmd_front
   import sio_cmd_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                CODE_LSB = 4,
   parameter int                MIN_GAP  = 3,
   parameter logic [DATA_W-1:0] MR1_RST  = '0,
   parameter logic [DATA_W-1:0] MR2_RST  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_rd,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mode_rdata,
   output logic              mr_sel,
   output logic              rx_reset_p,
   output logic              tx_reset_p,
   output logic              err_clr_p,
   output logic              brk_clr_p,
   output logic              ptr_reset_p,
   output logic              rts_n,
   output logic              gap_err
);

   if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_field
      $error("sio_cmd_front: command field does not fit in DATA_W");
   end

   logic     cmd_ok;
   cmd_dec_t dec;
   logic     rts_n_q;

   sio_cmd_gap #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cmd_wr),
      .ok    (cmd_ok),
      .viol  (gap_err)
   );

   sio_cmd_decode u_dec (
      .valid (cmd_wr && cmd_ok),
      .code  (wdata[CODE_LSB +: CODE_W]),
      .dec   (dec)
   );

   sio_mr_ptr #(
      .DATA_W  (DATA_W),
      .MR1_RST (MR1_RST),
      .MR2_RST (MR2_RST)
   ) u_mr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (mode_wr),
      .rd      (mode_rd),
      .wdata   (wdata),
      .ptr_clr (dec.ptr_rst),
      .rdata   (mode_rdata),
      .sel     (mr_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_n_q <= 1'b1;
      end else if (dec.rts_on) begin
         rts_n_q <= 1'b0;
      end else if (dec.rts_off) begin
         rts_n_q <= 1'b1;
      end
   end

   assign rts_n       = rts_n_q;
   assign rx_reset_p  = dec.rx_rst;
   assign tx_reset_p  = dec.tx_rst;
   assign err_clr_p   = dec.err_clr;
   assign brk_clr_p   = dec.brk_clr;
   assign ptr_reset_p = dec.ptr_rst;

endmodule

// File: rtl/sio_cmd_front_chk.sv
module sio_cmd_front_chk #(
   parameter int MIN_GAP = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_wr,
   input logic       mode_rd,
   input logic       cmd_wr,
   input logic [3:0] code,
   input logic       cmd_ok,
   input logic       mr_sel,
   input logic       rx_reset_p,
   input logic       tx_reset_p,
   input logic       err_clr_p,
   input logic       brk_clr_p,
   input logic       ptr_reset_p,
   input logic       rts_n,
   input logic       gap_err
);

   int   since_acc;
   logic any_p;

   assign any_p = rx_reset_p | tx_reset_p | err_clr_p | brk_clr_p | ptr_reset_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_acc <= MIN_GAP;
      end else if (cmd_wr && cmd_ok) begin
         since_acc <= 0;
      end else if (since_acc < MIN_GAP) begin
         since_acc <= since_acc + 1;
      end
   end

   a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!mr_sel && (mode_wr || mode_rd) && !ptr_reset_p) |=> mr_sel);

   a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_sel && !ptr_reset_p) |=> mr_sel);

   a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_reset_p |=> !mr_sel);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_reset_p, tx_reset_p, err_clr_p, brk_clr_p, ptr_reset_p}));

   a_r5_rx_source: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset_p |-> (cmd_wr && code == 4'h2));

   a_r6_brk_source: assert property (@(posedge clk) disable iff (!rst_n)
      brk_clr_p |-> (cmd_wr && code == 4'h5));

   a_r7_rts_on: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_ok && code == 4'h8) |=> !rts_n);

   a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !mode_wr && !mode_rd &&
       (code == 4'h0 || code == 4'hB || code == 4'hD))
      |=> ($stable(rts_n) && $stable(mr_sel)));

   a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_ok) |-> (since_acc >= MIN_GAP - 1));

   a_r9_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_ok) |-> !any_p);

   a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_ok) |=> gap_err);

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      gap_err |=> gap_err);

endmodule

bind sio_cmd_front sio_cmd_front_chk #(.MIN_GAP(MIN_GAP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_wr     (mode_wr),
   .mode_rd     (mode_rd),
   .cmd_wr      (cmd_wr),
   .code        (wdata[CODE_LSB +: 4]),
   .cmd_ok      (cmd_ok),
   .mr_sel      (mr_sel),
   .rx_reset_p  (rx_reset_p),
   .tx_reset_p  (tx_reset_p),
   .err_clr_p   (err_clr_p),
   .brk_clr_p   (brk_clr_p),
   .ptr_reset_p (ptr_reset_p),
   .rts_n       (rts_n),
   .gap_err     (gap_err)
);

// File: tb/sio_cmd_front_bench.sv
module sio_cmd_front_bench;

   localparam int CLK_NS = 8;
   localparam int NV     = 14;

   // entry: [13:10] code, [9:6] low nibble, [5:1] pulses {rx,tx,err,brk,ptr}, [0] rts_n after
   localparam logic [13:0] VEC [NV] = '{
      {4'h0, 4'hF, 5'b00000, 1'b1},
      {4'h2, 4'h0, 5'b10000, 1'b1},
      {4'h3, 4'h0, 5'b01000, 1'b1},
      {4'h4, 4'h0, 5'b00100, 1'b1},
      {4'h5, 4'h0, 5'b00010, 1'b1},
      {4'h1, 4'h0, 5'b00001, 1'b1},
      {4'h8, 4'h0, 5'b00000, 1'b0},
      {4'hB, 4'h0, 5'b00000, 1'b0},
      {4'hD, 4'h0, 5'b00000, 1'b0},
      {4'h6, 4'h5, 5'b00000, 1'b0},
      {4'h9, 4'h0, 5'b00000, 1'b1},
      {4'h8, 4'hF, 5'b00000, 1'b0},
      {4'hF, 4'h3, 5'b00000, 1'b0},
      {4'h9, 4'hA, 5'b00000, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic       mode_rd = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] mode_rdata;
   logic       mr_sel, rx_reset_p, tx_reset_p, err_clr_p, brk_clr_p, ptr_reset_p;
   logic       rts_n, gap_err;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sio_cmd_front u_sio_cmd_front (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_wr     (mode_wr),
      .mode_rd     (mode_rd),
      .cmd_wr      (cmd_wr),
      .wdata       (wdata),
      .mode_rdata  (mode_rdata),
      .mr_sel      (mr_sel),
      .rx_reset_p  (rx_reset_p),
      .tx_reset_p  (tx_reset_p),
      .err_clr_p   (err_clr_p),
      .brk_clr_p   (brk_clr_p),
      .ptr_reset_p (ptr_reset_p),
      .rts_n       (rts_n),
      .gap_err     (gap_err)
   );

   function automatic logic [4:0] pulses();
      return {rx_reset_p, tx_reset_p, err_clr_p, brk_clr_p, ptr_reset_p};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Called on a falling edge; samples pulses mid-cycle, returns on the next falling edge.
   task automatic step(input logic mw, input logic mr, input logic cw,
                       input logic [7:0] d, output logic [4:0] p);
      mode_wr = mw;
      mode_rd = mr;
      cmd_wr  = cw;
      wdata   = d;
      #2;
      p = pulses();
      @(negedge clk);
      mode_wr = 1'b0;
      mode_rd = 1'b0;
      cmd_wr  = 1'b0;
      wdata   = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [4:0] p;
      @(negedge clk);
      do_reset();

      // R1 reset state
      chk("R1 mr_sel", 32'(mr_sel), 0);
      chk("R1 rdata", 32'(mode_rdata), 0);
      chk("R1 rts_n", 32'(rts_n), 1);
      chk("R1 gap_err", 32'(gap_err), 0);
      chk("R1 pulses", 32'(pulses()), 0);

      // R5 R6 R7 R8 R11 table walk, writes spaced exactly three cycles (R9 boundary)
      for (int i = 0; i < NV; i++) begin
         step(1'b0, 1'b0, 1'b1, {VEC[i][13:10], VEC[i][9:6]}, p);
         chk($sformatf("R5/R6/R8 pulses vec%0d", i), 32'(p), 32'(VEC[i][5:1]));
         #1;
         chk($sformatf("R5 pulse width vec%0d", i), 32'(pulses()), 0);
         chk($sformatf("R7/R11 rts_n vec%0d", i), 32'(rts_n), 32'(VEC[i][0]));
         repeat (2) @(negedge clk);
      end
      chk("R9 no flag at boundary spacing", 32'(gap_err), 0);

      // R2 R3 mode pointer
      do_reset();
      step(1'b1, 1'b0, 1'b0, 8'hA5, p);
      chk("R2 pointer advanced", 32'(mr_sel), 1);
      step(1'b1, 1'b0, 1'b0, 8'h3C, p);
      chk("R3 pointer held after write", 32'(mr_sel), 1);
      chk("R3 second register data", 32'(mode_rdata), 32'h3C);
      step(1'b0, 1'b1, 1'b0, 8'h00, p);
      chk("R3 pointer held after read", 32'(mr_sel), 1);
      chk("R3 read shows second", 32'(mode_rdata), 32'h3C);

      // R4 pointer reset command
      step(1'b0, 1'b0, 1'b1, 8'h1F, p);
      chk("R4 pulse", 32'(p), 32'b00001);
      chk("R4 pointer back", 32'(mr_sel), 0);
      chk("R2 first register data", 32'(mode_rdata), 32'hA5);
      step(1'b0, 1'b1, 1'b0, 8'h00, p);
      chk("R2 read advances", 32'(mr_sel), 1);
      repeat (2) @(negedge clk);
      // R4 command wins over a concurrent write at the second register
      step(1'b1, 1'b0, 1'b1, 8'h17, p);
      chk("R4 concurrent pointer", 32'(mr_sel), 0);
      chk("R4 first register untouched", 32'(mode_rdata), 32'hA5);
      step(1'b0, 1'b1, 1'b0, 8'h00, p);
      chk("R4 concurrent write landed in second", 32'(mode_rdata), 32'h17);

      // R9 R10 spacing violation
      repeat (3) @(negedge clk);
      step(1'b0, 1'b0, 1'b1, 8'h80, p);
      chk("R7 rts low", 32'(rts_n), 0);
      step(1'b0, 1'b0, 1'b1, 8'h90, p);
      chk("R9 early write dropped rts", 32'(rts_n), 0);
      chk("R10 flag set", 32'(gap_err), 1);
      step(1'b0, 1'b0, 1'b1, 8'h20, p);
      chk("R9 early write no pulse", 32'(p), 0);
      step(1'b0, 1'b0, 1'b1, 8'h30, p);
      chk("R9 dropped writes do not restart window", 32'(p), 32'b01000);
      repeat (5) @(negedge clk);
      step(1'b0, 1'b0, 1'b1, 8'h40, p);
      chk("R6 err clear after gap", 32'(p), 32'b00100);
      chk("R10 flag sticky", 32'(gap_err), 1);

      // R1 reset mid-run clears state
      do_reset();
      chk("R1 rts after reset", 32'(rts_n), 1);
      chk("R1 flag after reset", 32'(gap_err), 0);
      chk("R1 pointer after reset", 32'(mr_sel), 0);
      chk("R1 register after reset", 32'(mode_rdata), 0);
      step(1'b0, 1'b0, 1'b1, 8'h20, p);
      chk("R9 first write after reset accepted", 32'(p), 32'b10000);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule